// File: doc/BRIEF.md
# Dual-Channel TDMA Cycle Sequencer

The sequencer walks one communication cycle of a time-triggered bus that has two broadcast channels, A and B. It advances one step for each `slot_tick` pulse. Every step reports a 2-bit phase code, a 1-based slot number and the controller that owns each channel. A cycle starts with a static part of P slots, where P is the number of controller pairs. Controllers 2k and 2k+1 share static slot k, one controller on each channel. Next comes a request phase of P mini-slots that share one slot number. After it comes a confirmation phase of P mini-slots, and then E dynamic extension slots. When the last step is done the cycle wraps to the start, and `cycle_start` pulses for one clock.

Three features stop a single faulty channel from always hiding the same controller's request. First, the confirmation phase swaps the channel mapping that the request phase used. Second, an alternating mode swaps the mapping of the static part and the request phase on every other cycle. Third, a double-request mode adds a second request phase with the swapped mapping, which makes the cycle P steps longer. The pair count, the extension length and the mode are taken in only at reset and at a cycle wrap. The `ext_used` input lets the dynamic traffic of a cycle end early: once it does, the remaining extension slots are reported as idle.

Top module: `tdma_cycle_seq`

## Requirements
- R1: During and right after reset, `phase` is 00, `slot_num` is 1, `owner_a` is 0, `owner_b` is 1 and `cycle_start` is 0.
- R2: Outputs change only in the clock after a clock in which `slot_tick` is high; otherwise every output keeps its value.
- R3: One cycle has P static steps (phase 00, slots 1..P), then P request steps (phase 01, slot P+1), then P confirmation steps (phase 10), then E extension steps (phase 11). Without double mode, the confirmation slot number is P+2 and extension step j (counted from 0) is slot P+3+j.
- R4: In static step k and request mini-slot k, the two owners are controllers 2k and 2k+1. The normal mapping puts 2k on channel A and 2k+1 on channel B.
- R5: Confirmation mini-slot k carries controllers 2k and 2k+1 with the mapping swapped against the mapping of the first request phase in the same cycle.
- R6: `cfg_mode` value 1 (alternating) swaps the mapping of the static part and of the request phase in every cycle with an odd index. The first cycle after reset has index 0, and the index counts every wrap whatever the mode.
- R7: `cfg_mode` value 2 (double request) inserts a second request phase of P steps with slot number P+2 and the swapped mapping. Confirmation then becomes slot P+3 and extension step j becomes slot P+4+j.
- R8: While the dynamic traffic of a cycle is still open, both owners in an extension step read all-ones minus one (14 at default width). If `ext_used` is low at the tick that ends an extension step, all later extension steps of that cycle read all-ones (15) on both owners. The next cycle opens the traffic again.
- R9: The tick that ends the last step of a cycle returns the sequencer to phase 00, slot 1. `cycle_start` is high for exactly the one clock after that tick.
- R10: The configuration inputs are sampled only during reset and at the wrap tick. A change in the middle of a cycle has no effect until the next wrap.
- R11: A pair count of 0 acts as 1. A pair count above MAX_PAIRS acts as MAX_PAIRS. An extension count above MAX_EXT acts as MAX_EXT. `cfg_mode` value 3 acts as value 0.
- R12: With an extension count of 0, the tick that ends the last confirmation step wraps the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the configuration |
| slot_tick | input | 1 | One-clock pulse that ends the current step |
| cfg_pairs | input | $clog2(MAX_PAIRS+1) | Controller pair count P |
| cfg_ext_slots | input | $clog2(MAX_EXT+1) | Extension slot count E |
| cfg_mode | input | 2 | 0 fixed, 1 alternating, 2 double request, 3 as 0 |
| ext_used | input | 1 | Low at a tick in an extension step ends dynamic traffic for this cycle |
| phase | output | 2 | 00 static, 01 request, 10 confirmation, 11 extension |
| slot_num | output | $clog2(MAX_PAIRS+MAX_EXT+4) | 1-based slot number |
| owner_a | output | $clog2(2*MAX_PAIRS+2) | Controller on channel A, or the dynamic/idle code |
| owner_b | output | $clog2(2*MAX_PAIRS+2) | Controller on channel B, or the dynamic/idle code |
| cycle_start | output | 1 | One-clock pulse after the wrap tick |

## Verification
Four things are checked on every clock, whatever the configuration: outputs hold between ticks; the two channels of a non-extension step always carry one controller pair; static slot numbers rise by one per tick until the request phase; and leaving the extension part always lands on slot 1 together with `cycle_start`. Other behaviour only shows up over whole cycles, so only the bench scenarios can reveal it. That covers the exact channel swap of the confirmation phase, the parity of the alternating mode, the slot numbering of the double-request mode, the idle marking after `ext_used` goes low, and the rule that configuration changes wait for the next wrap.

// File: rtl/tdma_seq_pkg.sv
package tdma_seq_pkg;

   typedef enum logic [1:0] {
      PH_STATIC = 2'b00,
      PH_REQ    = 2'b01,
      PH_CONF   = 2'b10,
      PH_EXT    = 2'b11
   } seq_phase_e;

   localparam logic [1:0] MODE_FIXED  = 2'd0;
   localparam logic [1:0] MODE_ALT    = 2'd1;
   localparam logic [1:0] MODE_DOUBLE = 2'd2;

endpackage

// File: rtl/tdma_cfg_latch.sv
// Holds the cycle configuration; reloads only at reset or at a cycle wrap.
module tdma_cfg_latch #(
   parameter int MAX_PAIRS     = 4,
   parameter int MAX_EXT       = 6,
   parameter int CW            = 3,
   parameter bit DOUBLE_REQ_EN = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic                                 load,
   input  logic [$clog2(MAX_PAIRS+1)-1:0]       cfg_pairs,
   input  logic [$clog2(MAX_EXT+1)-1:0]         cfg_ext_slots,
   input  logic [1:0]                           cfg_mode,
   output logic [CW-1:0]                        pairs_q,
   output logic [CW-1:0]                        ext_q,
   output logic                                 dbl,
   output logic                                 base_swap
);
   import tdma_seq_pkg::*;

   localparam logic [CW-1:0] PAIR_CAP = CW'(MAX_PAIRS);
   localparam logic [CW-1:0] EXT_CAP  = CW'(MAX_EXT);

   logic [CW-1:0] pairs_d, ext_d;
   logic [1:0]    mode_d, mode_q;
   logic          parity_q;

   always_comb begin
      pairs_d = CW'(cfg_pairs);
      if (pairs_d == '0)
         pairs_d = CW'(1);
      else if (pairs_d > PAIR_CAP)
         pairs_d = PAIR_CAP;
      ext_d = CW'(cfg_ext_slots);
      if (ext_d > EXT_CAP)
         ext_d = EXT_CAP;
      mode_d = (cfg_mode == 2'd3) ? MODE_FIXED : cfg_mode;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pairs_q  <= pairs_d;
         ext_q    <= ext_d;
         mode_q   <= mode_d;
         parity_q <= 1'b0;
      end else if (load) begin
         pairs_q  <= pairs_d;
         ext_q    <= ext_d;
         mode_q   <= mode_d;
         parity_q <= ~parity_q;
      end
   end

   generate
      if (DOUBLE_REQ_EN) begin : g_dbl
         assign dbl = (mode_q == MODE_DOUBLE);
      end else begin : g_no_dbl
         assign dbl = 1'b0;
      end
   endgenerate

   assign base_swap = (mode_q == MODE_ALT) & parity_q;

endmodule

// File: rtl/tdma_walker.sv
// Step state machine: phase, index inside the phase, request pass, traffic window.
module tdma_walker #(
   parameter int CW = 3
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        tick,
   input  logic                        ext_used,
   input  logic [CW-1:0]               pairs,
   input  logic [CW-1:0]               ext_n,
   input  logic                        dbl,
   output tdma_seq_pkg::seq_phase_e    ph_q,
   output logic [CW-1:0]               idx_q,
   output logic                        pass_q,
   output logic                        open_q,
   output logic                        start_q,
   output logic                        wrap_now
);
   import tdma_seq_pkg::*;

   logic [CW-1:0] last_pair, last_ext;
   logic          pair_end, ext_end;

   assign last_pair = pairs - CW'(1);
   assign last_ext  = ext_n - CW'(1);
   assign pair_end  = (idx_q == last_pair);
   assign ext_end   = (idx_q == last_ext);

   assign wrap_now = tick &&
      (((ph_q == PH_CONF) && pair_end && (ext_n == '0)) ||
       ((ph_q == PH_EXT) && ext_end));

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q    <= PH_STATIC;
         idx_q   <= '0;
         pass_q  <= 1'b0;
         open_q  <= 1'b1;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (wrap_now) begin
            ph_q    <= PH_STATIC;
            idx_q   <= '0;
            pass_q  <= 1'b0;
            open_q  <= 1'b1;
            start_q <= 1'b1;
         end else if (tick) begin
            case (ph_q)
               PH_STATIC: begin
                  if (pair_end) begin
                     ph_q  <= PH_REQ;
                     idx_q <= '0;
                  end else begin
                     idx_q <= idx_q + CW'(1);
                  end
               end
               PH_REQ: begin
                  if (pair_end) begin
                     idx_q <= '0;
                     if (dbl && !pass_q)
                        pass_q <= 1'b1;
                     else
                        ph_q <= PH_CONF;
                  end else begin
                     idx_q <= idx_q + CW'(1);
                  end
               end
               PH_CONF: begin
                  if (pair_end) begin
                     ph_q  <= PH_EXT;
                     idx_q <= '0;
                  end else begin
                     idx_q <= idx_q + CW'(1);
                  end
               end
               default: begin
                  if (!ext_used)
                     open_q <= 1'b0;
                  idx_q <= idx_q + CW'(1);
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/tdma_owner_map.sv
// Turns the step state into a slot number and the two channel owners.
module tdma_owner_map #(
   parameter int CW     = 3,
   parameter int SLOT_W = 4,
   parameter int OWN_W  = 4
) (
   input  tdma_seq_pkg::seq_phase_e ph,
   input  logic [CW-1:0]            idx,
   input  logic [CW-1:0]            pairs,
   input  logic                     pass,
   input  logic                     dbl,
   input  logic                     base_swap,
   input  logic                     open,
   output logic [SLOT_W-1:0]        slot_num,
   output logic [OWN_W-1:0]         own_a,
   output logic [OWN_W-1:0]         own_b
);
   import tdma_seq_pkg::*;

   localparam logic [OWN_W-1:0]  OWN_IDLE = {OWN_W{1'b1}};
   localparam logic [OWN_W-1:0]  OWN_DYN  = {OWN_W{1'b1}} - OWN_W'(1);
   localparam logic [SLOT_W-1:0] S_ONE    = SLOT_W'(1);
   localparam logic [SLOT_W-1:0] S_TWO    = SLOT_W'(2);
   localparam logic [SLOT_W-1:0] S_THREE  = SLOT_W'(3);

   logic              swap;
   logic [OWN_W-1:0]  even_id, odd_id;
   logic [SLOT_W-1:0] p_s, i_s, d_s;

   always_comb begin
      even_id = OWN_W'({idx, 1'b0});
      odd_id  = even_id | OWN_W'(1);
      p_s     = SLOT_W'(pairs);
      i_s     = SLOT_W'(idx);
      d_s     = SLOT_W'(dbl);
      case (ph)
         PH_STATIC: begin swap = base_swap;        slot_num = i_s + S_ONE; end
         PH_REQ:    begin swap = base_swap ^ pass; slot_num = p_s + S_ONE + SLOT_W'(pass); end
         PH_CONF:   begin swap = ~base_swap;       slot_num = p_s + S_TWO + d_s; end
         default:   begin swap = 1'b0;             slot_num = p_s + S_THREE + d_s + i_s; end
      endcase
      if (ph == PH_EXT) begin
         own_a = open ? OWN_DYN : OWN_IDLE;
         own_b = own_a;
      end else begin
         own_a = swap ? odd_id : even_id;
         own_b = swap ? even_id : odd_id;
      end
   end

endmodule

// File: rtl/tdma_cycle_seq.sv
module tdma_cycle_seq #(
   parameter int MAX_PAIRS     = 4,
   parameter int MAX_EXT       = 6,
   parameter bit DOUBLE_REQ_EN = 1'b1,
   localparam int PAIR_W = $clog2(MAX_PAIRS + 1),
   localparam int EXT_W  = $clog2(MAX_EXT + 1),
   localparam int SLOT_W = $clog2(MAX_PAIRS + MAX_EXT + 4),
   localparam int OWN_W  = $clog2(2 * MAX_PAIRS + 2)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              slot_tick,
   input  logic [PAIR_W-1:0] cfg_pairs,
   input  logic [EXT_W-1:0]  cfg_ext_slots,
   input  logic [1:0]        cfg_mode,
   input  logic              ext_used,
   output logic [1:0]        phase,
   output logic [SLOT_W-1:0] slot_num,
   output logic [OWN_W-1:0]  owner_a,
   output logic [OWN_W-1:0]  owner_b,
   output logic              cycle_start
);
   import tdma_seq_pkg::*;

   localparam int BIGGER = (MAX_PAIRS > MAX_EXT) ? MAX_PAIRS : MAX_EXT;
   localparam int CW     = $clog2(BIGGER + 1);

   generate
      if (MAX_PAIRS < 1) begin : g_bad_pairs
         $error("tdma_cycle_seq: MAX_PAIRS must be at least 1");
      end
      if (MAX_EXT < 1) begin : g_bad_ext
         $error("tdma_cycle_seq: MAX_EXT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] pairs_q, ext_q, idx_q;
   logic          dbl, base_swap, pass_q, open_q, wrap_now;
   seq_phase_e    ph_q;

   tdma_cfg_latch #(
      .MAX_PAIRS(MAX_PAIRS), .MAX_EXT(MAX_EXT), .CW(CW), .DOUBLE_REQ_EN(DOUBLE_REQ_EN)
   ) i_cfg (
      .clk(clk), .rst(rst), .load(wrap_now),
      .cfg_pairs(cfg_pairs), .cfg_ext_slots(cfg_ext_slots), .cfg_mode(cfg_mode),
      .pairs_q(pairs_q), .ext_q(ext_q), .dbl(dbl), .base_swap(base_swap)
   );

   tdma_walker #(.CW(CW)) i_walk (
      .clk(clk), .rst(rst), .tick(slot_tick), .ext_used(ext_used),
      .pairs(pairs_q), .ext_n(ext_q), .dbl(dbl),
      .ph_q(ph_q), .idx_q(idx_q), .pass_q(pass_q), .open_q(open_q),
      .start_q(cycle_start), .wrap_now(wrap_now)
   );

   tdma_owner_map #(.CW(CW), .SLOT_W(SLOT_W), .OWN_W(OWN_W)) i_map (
      .ph(ph_q), .idx(idx_q), .pairs(pairs_q), .pass(pass_q), .dbl(dbl),
      .base_swap(base_swap), .open(open_q),
      .slot_num(slot_num), .own_a(owner_a), .own_b(owner_b)
   );

   assign phase = ph_q;

endmodule

// File: rtl/tdma_seq_chk.sv
module tdma_seq_chk #(
   parameter int SLOT_W = 4,
   parameter int OWN_W  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              slot_tick,
   input logic [1:0]        phase,
   input logic [SLOT_W-1:0] slot_num,
   input logic [OWN_W-1:0]  owner_a,
   input logic [OWN_W-1:0]  owner_b,
   input logic              cycle_start
);
   localparam logic [OWN_W-1:0] IDLE_CODE = {OWN_W{1'b1}};

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
      !slot_tick |=> ($stable(phase) && $stable(slot_num) && $stable(owner_a)
                      && $stable(owner_b))); // R2

   AST_STATIC_COUNT: assert property (@(posedge clk) disable iff (rst)
      (slot_tick && phase == 2'b00) |=>
         ((phase == 2'b00 && slot_num == $past(slot_num) + SLOT_W'(1)) || phase == 2'b01)); // R3

   AST_PAIR_SHARED: assert property (@(posedge clk) disable iff (rst)
      (phase != 2'b11) |-> ((owner_a ^ owner_b) == OWN_W'(1))); // R4

   AST_IDLE_STICKS: assert property (@(posedge clk) disable iff (rst)
      (slot_tick && phase == 2'b11 && owner_a == IDLE_CODE) |=>
         (phase != 2'b11 || (owner_a == IDLE_CODE && owner_b == IDLE_CODE))); // R8

   AST_EXT_EXIT_WRAPS: assert property (@(posedge clk) disable iff (rst)
      (slot_tick && phase == 2'b11) |=> (phase == 2'b11 || (phase == 2'b00 && cycle_start))); // R9

   AST_START_AT_HEAD: assert property (@(posedge clk) disable iff (rst)
      cycle_start |-> (phase == 2'b00 && slot_num == SLOT_W'(1))); // R9

   AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
      cycle_start |=> !cycle_start); // R9

endmodule

bind tdma_cycle_seq tdma_seq_chk #(.SLOT_W(SLOT_W), .OWN_W(OWN_W)) i_chk (
   .clk(clk), .rst(rst), .slot_tick(slot_tick), .phase(phase), .slot_num(slot_num),
   .owner_a(owner_a), .owner_b(owner_b), .cycle_start(cycle_start)
);

// File: tb/test_tdma_cycle_seq.sv
module test_tdma_cycle_seq;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_PAIRS  = 4;
   localparam int MAX_EXT    = 6;
   localparam int PAIR_W     = $clog2(MAX_PAIRS + 1);
   localparam int EXT_W      = $clog2(MAX_EXT + 1);
   localparam int SLOT_W     = $clog2(MAX_PAIRS + MAX_EXT + 4);
   localparam int OWN_W      = $clog2(2 * MAX_PAIRS + 2);
   localparam int IDLE_ID    = (1 << OWN_W) - 1;
   localparam int DYN_ID     = IDLE_ID - 1;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              slot_tick = 1'b0;
   logic [PAIR_W-1:0] cfg_pairs = '0;
   logic [EXT_W-1:0]  cfg_ext_slots = '0;
   logic [1:0]        cfg_mode = '0;
   logic              ext_used = 1'b1;
   logic [1:0]        phase;
   logic [SLOT_W-1:0] slot_num;
   logic [OWN_W-1:0]  owner_a, owner_b;
   logic              cycle_start;

   int n_cmp = 0;
   int n_bad = 0;
   string sect = "R1";

   // reference model state
   int m_h, m_e, m_md, m_par, m_pos, m_open;
   bit m_start;

   always #(CLK_PERIOD/2) clk = ~clk;

   tdma_cycle_seq #(.MAX_PAIRS(MAX_PAIRS), .MAX_EXT(MAX_EXT)) i_tdma_cycle_seq (
      .clk(clk), .rst(rst), .slot_tick(slot_tick), .cfg_pairs(cfg_pairs),
      .cfg_ext_slots(cfg_ext_slots), .cfg_mode(cfg_mode), .ext_used(ext_used),
      .phase(phase), .slot_num(slot_num), .owner_a(owner_a), .owner_b(owner_b),
      .cycle_start(cycle_start)
   );

   task automatic chk(string tag, int got, int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s (%s) pos=%0d: got %0d expected %0d", tag, sect, m_pos, got, exp);
      end
   endtask

   task automatic latch_cfg();
      m_h  = (cfg_pairs == 0) ? 1 : ((int'(cfg_pairs) > MAX_PAIRS) ? MAX_PAIRS : int'(cfg_pairs));
      m_e  = (int'(cfg_ext_slots) > MAX_EXT) ? MAX_EXT : int'(cfg_ext_slots);
      m_md = (cfg_mode == 2'd3) ? 0 : int'(cfg_mode);
   endtask

   function automatic int cyc_len();
      return (3 + ((m_md == 2) ? 1 : 0)) * m_h + m_e;
   endfunction

   task automatic check_all(string pre);
      int dbl, base, ph, sl, k, sw, ea, eb;
      string otag;
      dbl  = (m_md == 2) ? 1 : 0;
      base = (m_md == 1) ? m_par : 0;
      k = 0; sw = 0;
      if (m_pos < m_h) begin
         ph = 0; sl = m_pos + 1; k = m_pos; sw = base; otag = (m_md == 1) ? "R6" : "R4";
      end else if (m_pos < 2 * m_h) begin
         ph = 1; sl = m_h + 1; k = m_pos - m_h; sw = base; otag = (m_md == 1) ? "R6" : "R4";
      end else if (dbl == 1 && m_pos < 3 * m_h) begin
         ph = 1; sl = m_h + 2; k = m_pos - 2 * m_h; sw = 1 - base; otag = "R7";
      end else if (m_pos < (3 + dbl) * m_h) begin
         ph = 2; sl = m_h + 2 + dbl; k = m_pos - (2 + dbl) * m_h; sw = 1 - base; otag = "R5";
      end else begin
         ph = 3; sl = m_h + 3 + dbl + (m_pos - (3 + dbl) * m_h); otag = "R8";
      end
      if (ph == 3) begin
         ea = m_open ? DYN_ID : IDLE_ID; eb = ea;
      end else begin
         ea = sw ? 2 * k + 1 : 2 * k;
         eb = sw ? 2 * k : 2 * k + 1;
      end
      chk({pre, "R3 phase"}, int'(phase), ph);
      chk({pre, (dbl == 1) ? "R7 slot" : "R3 slot"}, int'(slot_num), sl);
      chk({pre, otag, " owner_a"}, int'(owner_a), ea);
      chk({pre, otag, " owner_b"}, int'(owner_b), eb);
      chk({pre, "R9 cycle_start"}, int'(cycle_start), int'(m_start));
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      m_pos = 0; m_par = 0; m_open = 1; m_start = 1'b0;
      latch_cfg();
   endtask

   task automatic one_tick();
      @(negedge clk);
      slot_tick = 1'b1;
      @(negedge clk);
      slot_tick = 1'b0;
      if (m_pos >= cyc_len() - m_e && ext_used == 1'b0) m_open = 0;
      m_pos++;
      m_start = 1'b0;
      if (m_pos == cyc_len()) begin
         m_pos = 0; m_par ^= 1; m_open = 1; m_start = 1'b1;
         latch_cfg();
      end
      check_all("");
   endtask

   task automatic idle_clk();
      @(negedge clk);
      m_start = 1'b0;
      check_all("R2/");
   endtask

   task automatic run_ticks(int n);
      for (int i = 0; i < n; i++) one_tick();
   endtask

   task automatic set_cfg(int p, int e, int md);
      cfg_pairs = PAIR_W'(p); cfg_ext_slots = EXT_W'(e); cfg_mode = 2'(md);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      // R1: reset state
      set_cfg(2, 3, 0);
      ext_used = 1'b1;
      do_reset();
      sect = "R1 reset";
      chk("R1 phase", int'(phase), 0);
      chk("R1 slot", int'(slot_num), 1);
      chk("R1 owner_a", int'(owner_a), 0);
      chk("R1 owner_b", int'(owner_b), 1);
      chk("R1 cycle_start", int'(cycle_start), 0);
      idle_clk();

      sect = "R3 R4 R5 base";
      run_ticks(2 * cyc_len());

      // R8: end dynamic traffic after the first extension slot
      sect = "R8 early end";
      run_ticks(3 * m_h);
      ext_used = 1'b0;
      one_tick();
      ext_used = 1'b1;
      run_ticks(cyc_len() - m_pos);
      run_ticks(cyc_len());

      sect = "R6 alternating R10";
      set_cfg(3, 2, 1);
      one_tick();
      run_ticks(60);

      sect = "R7 double request";
      set_cfg(3, 2, 2);
      run_ticks(60);

      sect = "R12 no extension";
      set_cfg(1, 0, 0);
      run_ticks(30);

      sect = "R11 clamp low";
      set_cfg(0, 7, 3);
      run_ticks(40);
      sect = "R11 clamp high";
      set_cfg(7, 7, 2);
      run_ticks(60);

      sect = "R10 R2 random";
      for (int i = 0; i < 1500; i++) begin
         if ($urandom % 10 == 0) set_cfg($urandom % 8, $urandom % 8, $urandom % 4);
         ext_used = ($urandom % 4) != 0;
         one_tick();
         for (int g = 0; g < int'($urandom % 3); g++) idle_clk();
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule